// File: doc/BRIEF.md
# Double-Buffered Nibble-Addressable DAC Code Register

This block is the digital front end of a 12-bit multiplying converter. The 12-bit code arrives in three 4-bit groups. Each group is staged into its own input register, which is written when the shared active-low select is low and that group's own enable is high. A host on a 4-bit bus writes one group per cycle. A host on an 8-bit or 16-bit bus raises several group enables together. Staging a new value in pieces never disturbs the output.

A separate load strobe copies all staged bits at once into a holding register. Only the holding register drives the code output. The block is synchronous: every enable and strobe takes effect on a rising clock edge, in place of level-sensitive latches. The group width and the group count are parameters.

Top module: `dbf_dac_front`

## Requirements
- R1: A synchronous active-high reset clears both the staged input registers and the output code to zero. After reset, a load with no write in between yields a code of zero.
- R2: Group mapping uses enable bit 2 for the high group `din[11:8]`, where `din[11]` is the MSB. Enable bit 1 selects `din[7:4]`. Enable bit 0 selects the low group `din[3:0]`, where `din[0]` is the LSB. Each group lands in the same bit positions of `code`.
- R3: A group is written only at an edge where `cs_n` is 0 and its enable bit is 1. With `cs_n` at 1, every group enable is ignored.
- R4: A group whose write condition is false at an edge keeps its staged value.
- R5: Several enable bits high in the same cycle write all of the selected groups at that edge.
- R6: At an edge where `load` is 1, all 12 staged bits are copied in parallel into the output code. The new code is visible after that edge.
- R7: While `load` is 0, `code` does not change, even when staged registers are rewritten.
- R8: `load` acts regardless of the value of `cs_n`.
- R9: When a load and a group write fall on the same edge, `code` receives the staged contents from before the write. The newly written value reaches `code` on a later load.
- R10: A group enable held high over several cycles makes that group follow `din` at each edge. The group keeps the last value captured once the enable drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select for group writes, active low |
| grp_en | input | 3 | Per-group write enables, bit 2 = high group |
| din | input | 12 | Code input, bit 11 is the MSB |
| load | input | 1 | Copies the staged code to the output register |
| code | output | 12 | Held converter code |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. The edge that samples a load shows the copied code, and the edge that samples a reset shows zero. Staged writes have no port of their own. Each one is therefore observed through the code produced by the next load, one edge after that load.

The driver applies each input set on a falling edge and computes the code the requirements predict for the following rising edge. It queues that expectation together with the requirement tag. The monitor pops one entry a nanosecond after each rising edge and compares it with `code`, so every comparison falls in the cycle the result is due.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   localparam int unsigned DEF_GRP_W  = 4;
   localparam int unsigned DEF_N_GRPS = 3;

   // Lowest bit index of group g in the flat code vector.
   function automatic int unsigned grp_base(input int unsigned g, input int unsigned w);
      return g * w;
   endfunction
endpackage

// File: rtl/dbf_wr_decode.sv
module dbf_wr_decode #(
   parameter int unsigned N_GRPS = dbf_pkg::DEF_N_GRPS
) (
   input  logic              cs_n,
   input  logic [N_GRPS-1:0] grp_en,
   output logic [N_GRPS-1:0] grp_wr
);
   generate
      if (N_GRPS < 1) begin : g_bad_count
         $error("dbf_wr_decode: N_GRPS must be at least 1");
      end
   endgenerate

   always_comb begin
      for (int g = 0; g < int'(N_GRPS); g++) begin
         grp_wr[g] = grp_en[g] & ~cs_n;
      end
   end
endmodule

// File: rtl/dbf_nibble_reg.sv
module dbf_nibble_reg #(
   parameter int unsigned W = dbf_pkg::DEF_GRP_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("dbf_nibble_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (wr) q <= d;
   end

   // R4: an unwritten group keeps its value
   a_r4_group_holds: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(q));

   // R10: while written, the group tracks its input every edge
   a_r10_follows_input: assert property (@(posedge clk) disable iff (rst)
      wr |=> q == $past(d));
endmodule

// File: rtl/dbf_hold_reg.sv
module dbf_hold_reg #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("dbf_hold_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   // R7: the output code moves only on a load
   a_r7_code_stable: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

   // R6: a load copies every staged bit at once
   a_r6_parallel_copy: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d));
endmodule

// File: rtl/dbf_dac_front.sv
module dbf_dac_front #(
   parameter int unsigned GRP_W  = dbf_pkg::DEF_GRP_W,
   parameter int unsigned N_GRPS = dbf_pkg::DEF_N_GRPS
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cs_n,
   input  logic [N_GRPS-1:0]         grp_en,
   input  logic [GRP_W*N_GRPS-1:0]   din,
   input  logic                      load,
   output logic [GRP_W*N_GRPS-1:0]   code
);
   localparam int unsigned CODE_W = GRP_W * N_GRPS;

   generate
      if (GRP_W < 1 || N_GRPS < 1) begin : g_bad_shape
         $error("dbf_dac_front: group width and count must be positive");
      end
   endgenerate

   logic [N_GRPS-1:0] grp_wr;
   logic [CODE_W-1:0] staged;

   dbf_wr_decode #(.N_GRPS(N_GRPS)) i_decode (
      .cs_n   (cs_n),
      .grp_en (grp_en),
      .grp_wr (grp_wr)
   );

   // First rank: one register per group, group g at bits [g*GRP_W +: GRP_W]
   generate
      for (genvar g = 0; g < int'(N_GRPS); g++) begin : g_stage
         localparam int unsigned LO = dbf_pkg::grp_base(g, GRP_W);
         dbf_nibble_reg #(.W(GRP_W)) i_grp (
            .clk (clk),
            .rst (rst),
            .wr  (grp_wr[g]),
            .d   (din[LO +: GRP_W]),
            .q   (staged[LO +: GRP_W])
         );
      end
   endgenerate

   // Second rank: holding register that alone drives the code
   dbf_hold_reg #(.W(CODE_W)) i_hold (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (staged),
      .q    (code)
   );

   // R1: reset clears both ranks
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (code == '0) && (staged == '0));

   // R3: with the select inactive no group changes
   a_r3_select_blocks: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> $stable(staged));

   // R9: a load that coincides with a write takes the previous staged code
   a_r9_old_on_collision: assert property (@(posedge clk) disable iff (rst)
      (load && !cs_n && (|grp_en)) |=> code == $past(staged));
endmodule

// File: tb/test_dbf_dac_front.sv
module test_dbf_dac_front;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n = 1'b1;
   logic [2:0]  grp_en = '0;
   logic [11:0] din = '0;
   logic        load = 1'b0;
   logic [11:0] code;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [11:0] exp_q[$];
   string       tag_q[$];
   logic [11:0] m_code = '0;
   logic [11:0] m_stg  = '0;

   always #2 clk = ~clk;

   dbf_dac_front i_dbf_dac_front (
      .clk(clk), .rst(rst), .cs_n(cs_n), .grp_en(grp_en),
      .din(din), .load(load), .code(code)
   );

   task automatic step(input bit r, input bit csn, input bit [2:0] en,
                       input bit [11:0] d, input bit ld, input string tag);
      @(negedge clk);
      rst = r; cs_n = csn; grp_en = en; din = d; load = ld;
      if (r) begin
         m_code = '0;
         m_stg  = '0;
      end else begin
         if (ld) m_code = m_stg;
         if (!csn) begin
            for (int g = 0; g < 3; g++)
               if (en[g]) m_stg[g*4 +: 4] = d[g*4 +: 4];
         end
      end
      exp_q.push_back(m_code);
      tag_q.push_back(tag);
   endtask

   // Monitor: one expected item per rising edge, sampled 1 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() != 0) begin
            logic [11:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (code !== e) begin
               bad++;
               $display("FAIL %s: code=%h expected=%h", t, code, e);
            end
         end
      end
   end

   initial begin
      step(1, 1, 3'b000, 12'h000, 0, "R1 reset");
      step(1, 1, 3'b000, 12'h000, 0, "R1 reset");
      step(0, 0, 3'b100, 12'hA5C, 0, "R7 high write no load");
      step(0, 0, 3'b010, 12'h3B7, 0, "R7 mid write no load");
      step(0, 0, 3'b001, 12'h12D, 0, "R7 low write no load");
      step(0, 1, 3'b111, 12'hFFF, 1, "R8 load with cs_n high");
      step(0, 1, 3'b000, 12'h000, 1, "R3 cs_n high ignored enables");
      step(0, 0, 3'b111, 12'h123, 0, "R5 all groups one cycle");
      step(0, 0, 3'b000, 12'h000, 1, "R5 load multi write");
      step(0, 0, 3'b010, 12'h0F0, 1, "R9 load with write gets old");
      step(0, 0, 3'b000, 12'h000, 1, "R9 new value on next load");
      step(0, 0, 3'b001, 12'h004, 0, "R10 enable held 1");
      step(0, 0, 3'b001, 12'h005, 0, "R10 enable held 2");
      step(0, 0, 3'b001, 12'h006, 0, "R10 enable held 3");
      step(0, 0, 3'b000, 12'h00F, 1, "R10 last captured kept");
      step(0, 0, 3'b000, 12'hFFF, 1, "R4 unenabled groups hold");
      step(0, 0, 3'b100, 12'hE00, 0, "R2 high group only");
      step(0, 0, 3'b000, 12'h000, 1, "R2 high group maps to msbs");
      step(0, 0, 3'b001, 12'h008, 0, "R2 low group only");
      step(0, 0, 3'b000, 12'h000, 1, "R2 low group maps to lsbs");
      step(1, 0, 3'b000, 12'h000, 0, "R1 reset clears code");
      step(0, 0, 3'b000, 12'h000, 1, "R1 staged cleared by reset");
      step(0, 0, 3'b100, 12'h9AB, 0, "R2 write after reset");
      step(0, 0, 3'b000, 12'h000, 1, "R2 other groups zero after reset");
      step(0, 0, 3'b000, 12'h000, 0, "R7 idle");
      @(negedge clk);
      load = 1'b0;
      @(posedge clk);
      #2;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: code=%h expected=completion", code);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule